// File: doc/BRIEF.md
# UART Modem Handshake Status

This block is the modem-side control and status logic of a 16550-style serial port. It watches four active-low handshake inputs from a modem: carrier detect, data set ready, ring indicator and clear to send. It reports their levels and a sticky change flag for each through a status register, and it drives the active-low request-to-send output from a control register.

Each input passes through a two-flop synchronizer. The status register shows the levels in active-high sense. A change flag latches when its pin goes from low (asserted) back to high (deasserted). Any read of the status register clears all flags. A modem-status interrupt request follows the flags while its enable bit is set.

A loopback bit in the control register routes internal control bits into the status logic in place of the pins, so software can test the handshake path without a modem. Loopback also holds request-to-send at its inactive level.

Top module: `uart_modem_status`

## Requirements
- R1: Status register (address 6) bits 7, 6, 5 and 4 read the inverted, synchronized level of carrier detect, ring indicator, data set ready and clear to send. A pin change is visible on the second rising clock edge after it.
- R2: Status bits 3, 2, 1 and 0 are change flags for carrier detect, ring indicator, data set ready and clear to send. A flag is set when its pin goes from low to high, and it stays set until a status read.
- R3: A pin going from high to low (asserting) sets no change flag.
- R4: A read of the status register returns the flags as they stood before the read, and clears all four flags at that clock edge.
- R5: A low-to-high transition that is detected in the same cycle as a status read leaves its flag set after the read.
- R6: The interrupt enable register sits at address 1. Its bit 3 enables the modem-status interrupt. `irq` is high exactly while that bit is 1 and any change flag is set.
- R7: The control register sits at address 4 and holds five bits, [4:0]. Written bits 7..5 read back as 0. Outside loopback, `rts_n` is the inverse of control bit 1. After reset, `rts_n` is high and all registers read 0.
- R8: While control bit 4 (loopback) is 1, `rts_n` is held high whatever the value of bit 1.
- R9: In loopback the pins are ignored. Clear to send takes control bit 1, data set ready bit 0, ring indicator bit 2 and carrier detect bit 3. Change flags follow these internal levels under the same rules as R2 and R3.
- R10: The clear-to-send input changes only its status and flag bits. It never affects `rts_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (status read clears flags) |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr`, combinational |
| dcd_n | input | 1 | Carrier detect, active low |
| dsr_n | input | 1 | Data set ready, active low |
| ri_n | input | 1 | Ring indicator, active low |
| cts_n | input | 1 | Clear to send, active low |
| rts_n | output | 1 | Request to send, active low |
| irq | output | 1 | Modem-status interrupt request |

## Verification
The bench builds the block with its default parameters: a 3-bit address, 8-bit data, two synchronizer stages, and registers at addresses 1, 4 and 6. With two synchronizer stages, the cycle in which a deasserting pin edge reaches the change detector is fixed. The bench can therefore put a status read in exactly that cycle and show that the flag survives the clear. The 8-bit data width holds the full status byte, so each check compares levels and flags together.

// File: rtl/mdm_pkg.sv
// Shared definitions for the modem handshake status block.
// Assumes four handshake lines indexed in the order the status flags use.
package mdm_pkg;

    localparam int unsigned NLINES = 4;

    // Line index, equal to the change-flag bit position in the status register.
    typedef enum logic [1:0] {
        LN_CTS = 2'd0,
        LN_DSR = 2'd1,
        LN_RI  = 2'd2,
        LN_DCD = 2'd3
    } line_e;

    // Control register field positions.
    localparam int unsigned MCR_TRDY = 0;
    localparam int unsigned MCR_RTS  = 1;
    localparam int unsigned MCR_AUX1 = 2;
    localparam int unsigned MCR_AUX2 = 3;
    localparam int unsigned MCR_LOOP = 4;
    localparam int unsigned MCR_W    = 5;

    // Interrupt enable bit for modem-status events.
    localparam int unsigned IER_MSI  = 3;

    // Internal line levels (active high) used in loopback, indexed by line_e.
    function automatic logic [NLINES-1:0] loop_src(input logic [MCR_W-1:0] m);
        logic [NLINES-1:0] v;
        v[LN_CTS] = m[MCR_RTS];
        v[LN_DSR] = m[MCR_TRDY];
        v[LN_RI]  = m[MCR_AUX1];
        v[LN_DCD] = m[MCR_AUX2];
        return v;
    endfunction

endpackage

// File: rtl/mdm_sync.sv
// Multi-stage synchronizer for asynchronous pin inputs.
// Assumes STAGES >= 1; every stage resets to RST_VAL (the idle pin level).
module mdm_sync #(
    parameter int unsigned WIDTH   = 4,
    parameter int unsigned STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    // Shift the raw pin values through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(STAGES); i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < int'(STAGES); i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/mdm_change_det.sv
// Per-line deassertion detector with sticky flags.
// A flag sets when its active-high level falls (the pin goes low to high) and
// clears on clr. A new fall wins over a clear in the same cycle.
module mdm_change_det #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] level,
    input  logic         clr,
    output logic [N-1:0] fall,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < int'(N); i++) begin : g_line
        logic prev_q;
        logic flag_q;

        // Track the previous level and latch a sticky flag on a falling level.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prev_q <= 1'b0;
                flag_q <= 1'b0;
            end else begin
                prev_q <= level[i];
                if (fall[i])  flag_q <= 1'b1;
                else if (clr) flag_q <= 1'b0;
            end
        end

        assign fall[i]  = prev_q & ~level[i];
        assign flags[i] = flag_q;
    end
endmodule

// File: rtl/mdm_ctrl_regs.sv
// Control and interrupt-enable registers, and the request-to-send pin driver.
// Assumes DATA_W > MCR_W. Write bits above the control field are dropped.
module mdm_ctrl_regs
    import mdm_pkg::*;
#(
    parameter int unsigned ADDR_W   = 3,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned IER_ADDR = 1,
    parameter int unsigned MCR_ADDR = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [MCR_W-1:0]  mcr_q,
    output logic              msi_en,
    output logic              rts_n
);
    localparam logic [ADDR_W-1:0] A_IER = ADDR_W'(IER_ADDR);
    localparam logic [ADDR_W-1:0] A_MCR = ADDR_W'(MCR_ADDR);

    logic [DATA_W-1:0] wdata_unused;
    assign wdata_unused = wdata;

    // Store the control register on a write to its address.
    always_ff @(posedge clk) begin
        if (!rst_n)                        mcr_q <= '0;
        else if (wr_en && addr == A_MCR)   mcr_q <= wdata[MCR_W-1:0];
    end

    // Store the modem-status interrupt enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n)                        msi_en <= 1'b0;
        else if (wr_en && addr == A_IER)   msi_en <= wdata[IER_MSI];
    end

    // Drive the active-low request-to-send pin, held inactive in loopback.
    assign rts_n = mcr_q[MCR_LOOP] ? 1'b1 : ~mcr_q[MCR_RTS];
endmodule

// File: rtl/uart_modem_status.sv
// Modem handshake status and control for a 16550-style serial port.
// Synchronizes four active-low handshake pins, reports their levels and sticky
// deassertion flags, drives request-to-send, and raises a status interrupt.
// Assumes DATA_W >= 8 and distinct register addresses.
module uart_modem_status
    import mdm_pkg::*;
#(
    parameter int unsigned ADDR_W      = 3,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned IER_ADDR    = 1,
    parameter int unsigned MCR_ADDR    = 4,
    parameter int unsigned MSR_ADDR    = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              dcd_n,
    input  logic              dsr_n,
    input  logic              ri_n,
    input  logic              cts_n,
    output logic              rts_n,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] A_IER = ADDR_W'(IER_ADDR);
    localparam logic [ADDR_W-1:0] A_MCR = ADDR_W'(MCR_ADDR);
    localparam logic [ADDR_W-1:0] A_MSR = ADDR_W'(MSR_ADDR);

    logic [NLINES-1:0] pin_raw;
    logic [NLINES-1:0] pin_sync;
    logic [NLINES-1:0] line_lvl;
    logic [NLINES-1:0] chg_fall;
    logic [NLINES-1:0] chg_flags;
    logic [MCR_W-1:0]  mcr_q;
    logic              msi_en;
    logic              rd_msr;

    // Gather the pins in line_e order.
    assign pin_raw = {dcd_n, ri_n, dsr_n, cts_n};

    mdm_sync #(
        .WIDTH   (NLINES),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ({NLINES{1'b1}})
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_raw),
        .q     (pin_sync)
    );

    mdm_ctrl_regs #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .IER_ADDR (IER_ADDR),
        .MCR_ADDR (MCR_ADDR)
    ) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (reg_wr),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .mcr_q  (mcr_q),
        .msi_en (msi_en),
        .rts_n  (rts_n)
    );

    // Select the active-high line levels: the internal bits in loopback, else the pins.
    assign line_lvl = mcr_q[MCR_LOOP] ? loop_src(mcr_q) : ~pin_sync;

    // A status read clears the change flags.
    assign rd_msr = reg_rd && (reg_addr == A_MSR);

    mdm_change_det #(
        .N (NLINES)
    ) u_det (
        .clk   (clk),
        .rst_n (rst_n),
        .level (line_lvl),
        .clr   (rd_msr),
        .fall  (chg_fall),
        .flags (chg_flags)
    );

    // Register read multiplexer.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_MSR) begin
            reg_rdata[2*NLINES-1:0] = {line_lvl, chg_flags};
        end else if (reg_addr == A_MCR) begin
            reg_rdata[MCR_W-1:0] = mcr_q;
        end else if (reg_addr == A_IER) begin
            reg_rdata[IER_MSI] = msi_en;
        end
    end

    // Modem-status interrupt request.
    assign irq = msi_en & (|chg_flags);
endmodule

// File: rtl/mdm_checker.sv
// Protocol checker for uart_modem_status, attached by bind.
// Observes bus strobes, pins and internal flag and edge vectors.
module mdm_checker
    import mdm_pkg::*;
#(
    parameter int unsigned ADDR_W   = 3,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned MCR_ADDR = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              rts_n,
    input logic              irq,
    input logic              msi_en,
    input logic              rd_msr,
    input logic [NLINES-1:0] fall,
    input logic [NLINES-1:0] flags
);
    localparam logic [ADDR_W-1:0] A_MCR = ADDR_W'(MCR_ADDR);

    logic [DATA_W-1:0] wd_unused;
    assign wd_unused = reg_wdata;

    logic mcr_wr;
    assign mcr_wr = reg_wr && (reg_addr == A_MCR);

    assert_rts_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mcr_wr && !reg_wdata[MCR_LOOP]) |=> (rts_n == !$past(reg_wdata[MCR_RTS])));

    assert_rts_loop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mcr_wr && reg_wdata[MCR_LOOP]) |=> rts_n);

    assert_flag_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_msr |=> (($past(flags) & ~flags) == '0));

    assert_flag_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (flags & ~$past(flags) & ~$past(fall)) == '0);

    assert_flag_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_msr && fall == '0) |=> (flags == '0));

    assert_flag_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_msr && fall != '0) |=> ((flags & $past(fall)) == $past(fall)));

    assert_irq_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (msi_en && flags != '0));
endmodule

bind uart_modem_status mdm_checker #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .MCR_ADDR (MCR_ADDR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .rts_n     (rts_n),
    .irq       (irq),
    .msi_en    (msi_en),
    .rd_msr    (rd_msr),
    .fall      (chg_fall),
    .flags     (chg_flags)
);

// File: tb/sim_uart_modem_status.sv
`timescale 1ns/1ps
module sim_uart_modem_status;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 8;
    localparam logic [2:0] A_IER = 3'd1;
    localparam logic [2:0] A_MCR = 3'd4;
    localparam logic [2:0] A_MSR = 3'd6;

    localparam int K_RDATA = 0;
    localparam int K_RTS   = 1;
    localparam int K_IRQ   = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr = 1'b0;
    logic              reg_rd = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;
    logic dcd_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1, cts_n = 1'b1;
    logic rts_n, irq;

    always #5 clk = ~clk;

    uart_modem_status u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .dcd_n(dcd_n), .dsr_n(dsr_n), .ri_n(ri_n), .cts_n(cts_n),
        .rts_n(rts_n), .irq(irq)
    );

    typedef struct {
        string      req;
        int         kind;
        logic [7:0] exp;
    } item_t;

    item_t sbq[$];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Queue an expected observation for the monitor.
    task automatic push_exp(input string req, input int kind, input logic [7:0] e);
        item_t it;
        it.req  = req;
        it.kind = kind;
        it.exp  = e;
        sbq.push_back(it);
    endtask

    // Monitor: compare queued expectations 2 ns after each falling edge.
    initial begin
        forever begin
            item_t it;
            logic [7:0] act;
            @(negedge clk);
            #2;
            while (sbq.size() > 0) begin
                it = sbq.pop_front();
                case (it.kind)
                    K_RDATA: act = reg_rdata;
                    K_RTS:   act = {7'd0, rts_n};
                    default: act = {7'd0, irq};
                endcase
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s: actual %02h expected %02h", it.req, act, it.exp);
                end
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] e);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        push_exp(req, K_RDATA, e);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic out_chk(input string req, input int kind, input logic e);
        push_exp(req, kind, {7'd0, e});
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #2000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        idle(4);
        rst_n = 1'b1;

        // R7 reset state
        out_chk("R7 reset rts_n", K_RTS, 1'b1);
        out_chk("R6 reset irq", K_IRQ, 1'b0);
        rd_chk("R7 reset MSR", A_MSR, 8'h00);
        rd_chk("R7 reset MCR", A_MCR, 8'h00);
        rd_chk("R7 reset IER", A_IER, 8'h00);

        // R1 R3 R10: clear to send asserts, level only, rts_n unchanged
        cts_n = 1'b0;
        idle(4);
        out_chk("R10 cts low rts_n", K_RTS, 1'b1);
        rd_chk("R1 R3 cts asserted", A_MSR, 8'h10);
        cts_n = 1'b1;
        idle(4);
        out_chk("R10 cts high rts_n", K_RTS, 1'b1);
        rd_chk("R2 cts deasserted flag", A_MSR, 8'h01);
        rd_chk("R4 flags cleared by read", A_MSR, 8'h00);

        // R1 R2: other three lines
        dsr_n = 1'b0; ri_n = 1'b0; dcd_n = 1'b0;
        idle(4);
        rd_chk("R1 R3 three lines asserted", A_MSR, 8'hE0);
        dsr_n = 1'b1; ri_n = 1'b1; dcd_n = 1'b1;
        idle(4);
        out_chk("R6 irq masked", K_IRQ, 1'b0);
        wr_reg(A_IER, 8'h08);
        out_chk("R6 irq enabled with flags", K_IRQ, 1'b1);
        rd_chk("R6 IER readback", A_IER, 8'h08);
        rd_chk("R2 three flags", A_MSR, 8'h0E);
        out_chk("R6 irq drops after read", K_IRQ, 1'b0);
        rd_chk("R4 cleared", A_MSR, 8'h00);

        // R5: deassert edge meets the status read in the same cycle
        dcd_n = 1'b0;
        idle(4);
        rd_chk("R1 dcd asserted", A_MSR, 8'h80);
        dcd_n = 1'b1;
        idle(1);
        rd_chk("R5 read during edge", A_MSR, 8'h00);
        out_chk("R5 irq after collision", K_IRQ, 1'b1);
        rd_chk("R5 flag kept", A_MSR, 8'h08);
        rd_chk("R4 cleared after collision", A_MSR, 8'h00);

        // R7 request to send
        wr_reg(A_MCR, 8'h02);
        out_chk("R7 rts asserted", K_RTS, 1'b0);
        rd_chk("R7 MCR readback", A_MCR, 8'h02);
        wr_reg(A_MCR, 8'hE2);
        rd_chk("R7 MCR upper bits dropped", A_MCR, 8'h02);

        // R8 R9 loopback
        wr_reg(A_MCR, 8'h12);
        out_chk("R8 loop forces rts_n high", K_RTS, 1'b1);
        rd_chk("R9 loop cts from rts bit", A_MSR, 8'h10);
        cts_n = 1'b0; dcd_n = 1'b0;
        idle(4);
        rd_chk("R9 pins ignored in loop", A_MSR, 8'h10);
        cts_n = 1'b1; dcd_n = 1'b1;
        idle(4);
        rd_chk("R9 pin release ignored", A_MSR, 8'h10);
        wr_reg(A_MCR, 8'h1F);
        out_chk("R8 loop rts_n high with rts bit", K_RTS, 1'b1);
        rd_chk("R9 loop all levels", A_MSR, 8'hF0);
        wr_reg(A_MCR, 8'h10);
        idle(1);
        out_chk("R9 R6 loop flags raise irq", K_IRQ, 1'b1);
        rd_chk("R9 loop falls set flags", A_MSR, 8'h0F);
        wr_reg(A_MCR, 8'h00);
        out_chk("R7 rts_n inactive after loop", K_RTS, 1'b1);
        rd_chk("R9 back to pins", A_MSR, 8'h00);

        idle(3);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule